// File: doc/BRIEF.md
# Serial Command Decoder for a Four-Channel Digital Potentiometer

This block is the serial slave front end of a four-channel digital potentiometer. A host frames each command with a low chip select. The host sends an identification byte, then an instruction byte, and for some commands a data byte, MSB first. Each channel has one volatile 8-bit wiper register, which is driven straight to the analog side, and four 8-bit storage registers. The host can read and write these registers, copy between them for one channel, or copy for all channels at once. Register contents come back on a serial output that has its own output enable.

All serial pins are sampled by the fast system clock through a synchronizer. Edges of the serial clock are found from those samples. Each SCK phase must therefore last at least SYNC_STAGES + 5 cycles of `clk`. A write into a storage register is committed only at the end of a complete frame. The commit raises a one-cycle request for the separate nonvolatile write controller. That controller's busy flag comes back in as the write-in-progress status.

Top module: `dpot_spi_cmd`

## Requirements
- R1: After reset, the storage register 0 of channel c holds 0x80 + 0x10*c. One cycle later each wiper equals that value (0x80, 0x90, 0xA0, 0xB0). so_oe and nv_req are low.
- R2: The first byte of a frame must be 0101 in bits 7:4, 00 in bits 3:2 and addr_pins in bits 1:0. If it does not match, the rest of the frame changes no register and so_oe stays low.
- R3: The instruction byte carries the opcode in bits 7:4, the storage-register select in bits 3:2 and the channel in bits 1:0. Opcode 1010 with a data byte writes the wiper. Opcode 1001 returns the wiper on SO during the third byte, MSB first, with SO changing after falling SCK edges.
- R4: Opcode 1100 with a data byte writes the selected storage register when wp_n is high. Opcode 1011 reads it back. Each accepted storage write raises nv_req for exactly one cycle.
- R5: While wp_n is low, no storage register changes and nv_req stays low. Reads still work.
- R6: The two-byte opcode 1101 copies storage register to wiper for one channel. The two-byte opcode 1110 copies wiper to storage register and raises nv_req.
- R7: The two-byte opcode 0001 loads every wiper from its own storage register at the selected index. The two-byte opcode 1000 stores every wiper into the storage register at the selected index.
- R8: Instruction byte 0101_0001 returns 0000000 followed by nv_busy in the LSB.
- R9: so_oe is low whenever cs_n is high, and outside the data byte of an accepted read.
- R10: hold_n taken low while SCK is low pauses the frame. SCK edges and SO are ignored, and so_oe is low. Taking hold_n high while SCK is low resumes the same frame.
- R11: A command takes effect at cs_n rising only if exactly its frame length was received: 16 bits for copies, 24 bits for the rest. Shorter or longer frames, unsupported opcodes and opcode 0010 change no register.
- R12: After reset, no frame is accepted until cs_n has gone high and then low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low reset (power-up) |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low frame pause |
| wp_n | input | 1 | Active-low write protect for storage registers |
| addr_pins | input | 2 | Strapped device address |
| nv_busy | input | 1 | Write-in-progress flag from the nonvolatile controller |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |
| nv_req | output | 1 | One-cycle request to commit a storage register |
| wiper_o | output | 32 | Wiper positions, channel c in bits 8c+7:8c |

## Verification
A register change is visible on wiper_o about SYNC_STAGES + 3 clk cycles after cs_n rises. A SO bit is valid about SYNC_STAGES + 2 cycles after a falling SCK edge. The bench holds every SCK phase and the post-frame gap for 12 cycles. It samples SO just before the next rising SCK edge and checks registers only after the gap, so each check falls well after its result is due. Register contents are checked through the read commands and wiper_o. nv_req pulses are counted by a monitor.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
   localparam int CH_N  = 4;
   localparam int REG_N = 4;
   localparam int DAT_W = 8;

   localparam logic [3:0] DEV_ID   = 4'b0101;
   localparam logic [3:0] OP_RD_W  = 4'b1001;
   localparam logic [3:0] OP_WR_W  = 4'b1010;
   localparam logic [3:0] OP_RD_D  = 4'b1011;
   localparam logic [3:0] OP_WR_D  = 4'b1100;
   localparam logic [3:0] OP_D2W   = 4'b1101;
   localparam logic [3:0] OP_W2D   = 4'b1110;
   localparam logic [3:0] OP_GD2W  = 4'b0001;
   localparam logic [3:0] OP_GW2D  = 4'b1000;
   localparam logic [7:0] STAT_INS = 8'b0101_0001;

   typedef enum logic [2:0] {
      ACT_NONE, ACT_WR_W, ACT_WR_D, ACT_D2W, ACT_W2D, ACT_GD2W, ACT_GW2D
   } act_e;

   typedef struct packed {
      act_e             act;
      logic [1:0]       ch;
      logic [1:0]       sel;
      logic [DAT_W-1:0] data;
   } exec_t;

   // Exact frame length in bits for an instruction byte, 0 if unsupported
   function automatic int unsigned frame_bits(input logic [7:0] ins);
      case (ins[7:4])
         OP_RD_W, OP_WR_W, OP_RD_D, OP_WR_D: frame_bits = 24;
         OP_D2W, OP_W2D, OP_GD2W, OP_GW2D:   frame_bits = 16;
         DEV_ID:  frame_bits = (ins == STAT_INS) ? 24 : 0;
         default: frame_bits = 0;
      endcase
   endfunction

   function automatic act_e act_of(input logic [3:0] op);
      case (op)
         OP_WR_W: act_of = ACT_WR_W;
         OP_WR_D: act_of = ACT_WR_D;
         OP_D2W:  act_of = ACT_D2W;
         OP_W2D:  act_of = ACT_W2D;
         OP_GD2W: act_of = ACT_GD2W;
         OP_GW2D: act_of = ACT_GW2D;
         default: act_of = ACT_NONE;
      endcase
   endfunction

   function automatic logic is_nv(input act_e a);
      is_nv = (a == ACT_WR_D) || (a == ACT_W2D) || (a == ACT_GW2D);
   endfunction
endpackage

// File: rtl/dpot_spi_front.sv
module dpot_spi_front #(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 5,
   parameter int DW          = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sck,
   input  logic             si,
   input  logic             cs_n,
   input  logic             hold_n,
   input  logic             rd_phase,
   input  logic             tx_load,
   input  logic [DW-1:0]    tx_data,
   output logic             cs_fall,
   output logic             frame_end,
   output logic [CNT_W-1:0] bit_count,
   output logic             byte_valid,
   output logic [CNT_W-4:0] byte_idx,
   output logic [DW-1:0]    rx_byte,
   output logic             so,
   output logic             so_oe,
   output logic             cs_high,
   output logic             hold_act
);
   localparam int BIT_W = $clog2(DW);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic sck_s, si_s, cs_s, hold_s;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign sck_s  = sck;
         assign si_s   = si;
         assign cs_s   = cs_n;
         assign hold_s = hold_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sck_p, si_p, cs_p, hold_p;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_p  <= '0;
               si_p   <= '0;
               cs_p   <= '0;   // low: a select held low through reset is not a frame start
               hold_p <= '1;
            end else begin
               sck_p[0]  <= sck;
               si_p[0]   <= si;
               cs_p[0]   <= cs_n;
               hold_p[0] <= hold_n;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sck_p[i]  <= sck_p[i-1];
                  si_p[i]   <= si_p[i-1];
                  cs_p[i]   <= cs_p[i-1];
                  hold_p[i] <= hold_p[i-1];
               end
            end
         end
         assign sck_s  = sck_p[SYNC_STAGES-1];
         assign si_s   = si_p[SYNC_STAGES-1];
         assign cs_s   = cs_p[SYNC_STAGES-1];
         assign hold_s = hold_p[SYNC_STAGES-1];
      end
   endgenerate

   logic            sck_d, cs_d, open_q, hold_q;
   logic [CNT_W-1:0] cnt_q;
   logic [DW-2:0]   sh_q;
   logic [DW-1:0]   tx_q;
   logic            so_q, oe_q, bv_q;
   logic [CNT_W-4:0] bidx_q;
   logic [DW-1:0]   rx_q;

   logic active, sck_rise, sck_fall, cs_rise;
   assign active   = open_q & ~cs_s & ~hold_q;
   assign sck_rise = active & sck_s & ~sck_d;
   assign sck_fall = active & ~sck_s & sck_d;
   assign cs_fall  = cs_d & ~cs_s;
   assign cs_rise  = ~cs_d & cs_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d  <= 1'b0;
         cs_d   <= 1'b0;
         open_q <= 1'b0;
         hold_q <= 1'b0;
         cnt_q  <= '0;
         sh_q   <= '0;
         tx_q   <= '0;
         so_q   <= 1'b0;
         oe_q   <= 1'b0;
         bv_q   <= 1'b0;
         bidx_q <= '0;
         rx_q   <= '0;
      end else begin
         sck_d <= sck_s;
         cs_d  <= cs_s;
         bv_q  <= 1'b0;
         if (cs_fall)      open_q <= 1'b1;
         else if (cs_rise) open_q <= 1'b0;
         // pause state only moves while the serial clock is low
         if (cs_s)        hold_q <= 1'b0;
         else if (!sck_s) hold_q <= ~hold_s;
         if (cs_fall) cnt_q <= '0;
         else if (sck_rise && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         if (sck_rise) begin
            sh_q <= {sh_q[DW-3:0], si_s};
            if (cnt_q[BIT_W-1:0] == BIT_W'(DW-1)) begin
               bv_q   <= 1'b1;
               bidx_q <= cnt_q[CNT_W-1:BIT_W];
               rx_q   <= {sh_q, si_s};
            end
         end
         if (tx_load) tx_q <= tx_data;
         else if (sck_fall) begin
            so_q <= tx_q[DW-1];
            tx_q <= {tx_q[DW-2:0], 1'b0};
         end
         oe_q <= rd_phase & open_q & ~cs_s & ~hold_q;
      end
   end

   assign frame_end  = cs_rise & open_q;
   assign bit_count  = cnt_q;
   assign byte_valid = bv_q;
   assign byte_idx   = bidx_q;
   assign rx_byte    = rx_q;
   assign so         = so_q;
   assign so_oe      = oe_q;
   assign cs_high    = cs_s;
   assign hold_act   = hold_q;
endmodule

// File: rtl/dpot_cmd_decode.sv
module dpot_cmd_decode
   import dpot_pkg::*;
#(
   parameter int CH    = 4,
   parameter int NREG  = 4,
   parameter int DW    = 8,
   parameter int CNT_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_fall,
   input  logic               frame_end,
   input  logic [CNT_W-1:0]   bit_count,
   input  logic               byte_valid,
   input  logic [CNT_W-4:0]   byte_idx,
   input  logic [DW-1:0]      rx_byte,
   input  logic [1:0]         addr_pins,
   input  logic               wp_n,
   input  logic               nv_busy,
   input  logic [CH*DW-1:0]   wiper_flat,
   input  logic [CH*NREG*DW-1:0] dr_flat,
   output logic               rd_phase,
   output logic               tx_load,
   output logic [DW-1:0]      tx_data,
   output logic               exec_valid,
   output exec_t              exec,
   output logic               nv_req
);
   logic          id_ok_q, ins_ok_q;
   logic [DW-1:0] ins_q, dat_q;

   logic [DW-1:0] id_expect, rd_val;
   logic          is_read;
   int unsigned   len;
   act_e          act;

   assign id_expect = {DEV_ID, 2'b00, addr_pins};
   assign is_read   = (rx_byte[7:4] == OP_RD_W) || (rx_byte[7:4] == OP_RD_D) ||
                      (rx_byte == STAT_INS);
   assign len       = frame_bits(ins_q);
   assign act       = act_of(ins_q[7:4]);

   always_comb begin
      if (rx_byte == STAT_INS)
         rd_val = {{(DW-1){1'b0}}, nv_busy};
      else if (rx_byte[7:4] == OP_RD_W)
         rd_val = wiper_flat[int'(rx_byte[1:0])*DW +: DW];
      else
         rd_val = dr_flat[(int'(rx_byte[1:0])*NREG + int'(rx_byte[3:2]))*DW +: DW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_ok_q    <= 1'b0;
         ins_ok_q   <= 1'b0;
         ins_q      <= '0;
         dat_q      <= '0;
         rd_phase   <= 1'b0;
         tx_load    <= 1'b0;
         tx_data    <= '0;
         exec_valid <= 1'b0;
         exec       <= '0;
         nv_req     <= 1'b0;
      end else begin
         tx_load    <= 1'b0;
         exec_valid <= 1'b0;
         nv_req     <= 1'b0;
         if (cs_fall) begin
            id_ok_q  <= 1'b0;
            ins_ok_q <= 1'b0;
            rd_phase <= 1'b0;
         end else if (byte_valid) begin
            case (byte_idx)
               2'd0: id_ok_q <= (rx_byte == id_expect);
               2'd1: if (id_ok_q) begin
                  ins_q    <= rx_byte;
                  ins_ok_q <= 1'b1;
                  if (is_read) begin
                     rd_phase <= 1'b1;
                     tx_load  <= 1'b1;
                     tx_data  <= rd_val;
                  end
               end
               2'd2: dat_q <= rx_byte;
               default: ;
            endcase
         end else if (frame_end) begin
            rd_phase <= 1'b0;
            if (id_ok_q && ins_ok_q && len != 0 && 32'(bit_count) == len &&
                act != ACT_NONE && !(is_nv(act) && !wp_n)) begin
               exec_valid <= 1'b1;
               exec.act   <= act;
               exec.ch    <= ins_q[1:0];
               exec.sel   <= ins_q[3:2];
               exec.data  <= dat_q;
               nv_req     <= is_nv(act);
            end
         end
      end
   end
endmodule

// File: rtl/dpot_reg_bank.sv
module dpot_reg_bank
   import dpot_pkg::*;
#(
   parameter int CH       = 4,
   parameter int NREG     = 4,
   parameter int DW       = 8,
   parameter int DR0_INIT = 128,
   parameter int DR0_STEP = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  exec_valid,
   input  exec_t                 exec,
   output logic [CH*DW-1:0]      wiper_flat,
   output logic [CH*NREG*DW-1:0] dr_flat,
   output logic                  boot_load
);
   logic boot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) boot_q <= 1'b1;
      else        boot_q <= 1'b0;
   end
   assign boot_load = boot_q;

   generate
      for (genvar c = 0; c < CH; c++) begin : g_ch
         localparam logic [DW-1:0] RST0 = DW'(DR0_INIT + c * DR0_STEP);
         logic [DW-1:0] wip_q;
         logic [DW-1:0] dr_q [NREG];
         logic          hit;
         assign hit = (int'(exec.ch) == c);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wip_q <= '0;
               for (int r = 0; r < NREG; r++) dr_q[r] <= (r == 0) ? RST0 : '0;
            end else if (boot_q) begin
               wip_q <= dr_q[0];
            end else if (exec_valid) begin
               case (exec.act)
                  ACT_WR_W: if (hit) wip_q <= exec.data;
                  ACT_D2W:  if (hit) wip_q <= dr_q[exec.sel];
                  ACT_GD2W: wip_q <= dr_q[exec.sel];
                  ACT_WR_D: if (hit) dr_q[exec.sel] <= exec.data;
                  ACT_W2D:  if (hit) dr_q[exec.sel] <= wip_q;
                  ACT_GW2D: dr_q[exec.sel] <= wip_q;
                  default: ;
               endcase
            end
         end

         assign wiper_flat[c*DW +: DW] = wip_q;
         for (genvar r = 0; r < NREG; r++) begin : g_reg
            assign dr_flat[(c*NREG + r)*DW +: DW] = dr_q[r];
         end
      end
   endgenerate
endmodule

// File: rtl/dpot_spi_cmd.sv
module dpot_spi_cmd
   import dpot_pkg::*;
#(
   parameter int CHANNELS    = 4,
   parameter int REGS_PER_CH = 4,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DR0_INIT    = 128,
   parameter int DR0_STEP    = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sck,
   input  logic                       si,
   input  logic                       cs_n,
   input  logic                       hold_n,
   input  logic                       wp_n,
   input  logic [1:0]                 addr_pins,
   input  logic                       nv_busy,
   output logic                       so,
   output logic                       so_oe,
   output logic                       nv_req,
   output logic [CHANNELS*DATA_W-1:0] wiper_o
);
   localparam int CNT_W = $clog2(3*DATA_W + 2);

   generate
      if (CHANNELS != CH_N || REGS_PER_CH != REG_N || DATA_W != DAT_W) begin : g_bad_fmt
         $error("command format fixes four channels, four registers and 8-bit data");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic                   cs_fall, frame_end, byte_valid, cs_high, hold_act;
   logic [CNT_W-1:0]       bit_count;
   logic [CNT_W-4:0]       byte_idx;
   logic [DATA_W-1:0]      rx_byte, tx_data;
   logic                   rd_phase, tx_load, exec_valid, boot_load;
   exec_t                  exec;
   logic [CHANNELS*DATA_W-1:0]             wiper_flat;
   logic [CHANNELS*REGS_PER_CH*DATA_W-1:0] dr_flat;

   dpot_spi_front #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W), .DW(DATA_W)) u_front (
      .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n), .hold_n(hold_n),
      .rd_phase(rd_phase), .tx_load(tx_load), .tx_data(tx_data),
      .cs_fall(cs_fall), .frame_end(frame_end), .bit_count(bit_count),
      .byte_valid(byte_valid), .byte_idx(byte_idx), .rx_byte(rx_byte),
      .so(so), .so_oe(so_oe), .cs_high(cs_high), .hold_act(hold_act)
   );

   dpot_cmd_decode #(.CH(CHANNELS), .NREG(REGS_PER_CH), .DW(DATA_W), .CNT_W(CNT_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .frame_end(frame_end),
      .bit_count(bit_count), .byte_valid(byte_valid), .byte_idx(byte_idx),
      .rx_byte(rx_byte), .addr_pins(addr_pins), .wp_n(wp_n), .nv_busy(nv_busy),
      .wiper_flat(wiper_flat), .dr_flat(dr_flat), .rd_phase(rd_phase),
      .tx_load(tx_load), .tx_data(tx_data), .exec_valid(exec_valid),
      .exec(exec), .nv_req(nv_req)
   );

   dpot_reg_bank #(.CH(CHANNELS), .NREG(REGS_PER_CH), .DW(DATA_W),
                   .DR0_INIT(DR0_INIT), .DR0_STEP(DR0_STEP)) u_bank (
      .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .exec(exec),
      .wiper_flat(wiper_flat), .dr_flat(dr_flat), .boot_load(boot_load)
   );

   assign wiper_o = wiper_flat;
endmodule

// File: rtl/dpot_spi_cmd_chk.sv
module dpot_spi_cmd_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cs_high,
   input logic         hold_act,
   input logic         so_oe,
   input logic         nv_req,
   input logic         wp_n,
   input logic         exec_valid,
   input logic         boot_load,
   input logic         frame_end,
   input logic [W-1:0] wiper_o
);
   p_oe_off_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cs_high |=> !so_oe);

   p_oe_off_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hold_act |=> !so_oe);

   p_nv_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      nv_req |=> !nv_req);

   p_nv_with_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      nv_req |-> exec_valid);

   p_nv_protect_r5: assert property (@(posedge clk) disable iff (!rst_n)
      nv_req |-> $past(wp_n));

   p_exec_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
      exec_valid |-> $past(frame_end));

   p_wiper_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec_valid && !boot_load) |=> $stable(wiper_o));
endmodule

bind dpot_spi_cmd dpot_spi_cmd_chk #(.W(CHANNELS*DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_high(cs_high), .hold_act(hold_act),
   .so_oe(so_oe), .nv_req(nv_req), .wp_n(wp_n), .exec_valid(exec_valid),
   .boot_load(boot_load), .frame_end(frame_end), .wiper_o(wiper_o)
);

// File: tb/dpot_spi_cmd_tb.sv
`timescale 1ns/1ps
module dpot_spi_cmd_tb;
   localparam int HALF = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0, si = 1'b0, cs_n = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
   logic [1:0]  addr_pins = 2'b10;
   logic        nv_busy = 1'b0;
   logic        so, so_oe, nv_req;
   logic [31:0] wiper_o;

   int n_chk = 0, n_bad = 0;
   int nv_hi = 0, nv_rise = 0, oe_hi = 0, oe_idle_bad = 0, cs_run = 0, cycles = 0;
   logic nv_prev = 1'b0;
   bit done = 0;

   always #2 clk = ~clk;

   dpot_spi_cmd u_dut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n), .hold_n(hold_n),
      .wp_n(wp_n), .addr_pins(addr_pins), .nv_busy(nv_busy),
      .so(so), .so_oe(so_oe), .nv_req(nv_req), .wiper_o(wiper_o)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      nv_prev <= nv_req;
      if (nv_req) nv_hi <= nv_hi + 1;
      if (nv_req && !nv_prev) nv_rise <= nv_rise + 1;
      if (so_oe) oe_hi <= oe_hi + 1;
      cs_run <= cs_n ? cs_run + 1 : 0;
      if (cs_run > 6 && so_oe) oe_idle_bad <= oe_idle_bad + 1;
      if (cycles > 150000 && !done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog (all reqs): actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] idb();
      return {4'b0101, 2'b00, addr_pins};
   endfunction

   function automatic logic [7:0] wip(input int c);
      return wiper_o[c*8 +: 8];
   endfunction

   // Shift a frame; bits beyond 24 send 0. hold_at pauses before that bit.
   task automatic xfer(input logic [23:0] v, input int n, input int hold_at,
                       input bit no_fall, output logic [7:0] rx, output bit oe_ok);
      rx = '0; oe_ok = 1;
      if (!no_fall) cs_n = 1'b0;
      cyc(HALF);
      for (int i = 0; i < n; i++) begin
         if (i == hold_at) begin
            hold_n = 1'b0;
            cyc(4);
            for (int k = 0; k < 2; k++) begin
               si = ~si; sck = 1'b1; cyc(HALF); sck = 1'b0; cyc(HALF);
            end
            if (so_oe !== 1'b0) oe_ok = 0;
            hold_n = 1'b1;
            cyc(HALF);
         end
         si = (i < 24) ? v[23-i] : 1'b0;
         cyc(HALF);
         if (i >= 16) begin
            rx = {rx[6:0], so};
            if (so_oe !== 1'b1) oe_ok = 0;
         end
         sck = 1'b1; cyc(HALF); sck = 1'b0;
      end
      cyc(HALF);
      cs_n = 1'b1;
      cyc(16);
   endtask

   task automatic send(input logic [7:0] id, input logic [3:0] op, input logic [1:0] sel,
                       input logic [1:0] ch, input logic [7:0] d, input int n);
      logic [7:0] rx; bit ok;
      xfer({id, op, sel, ch, d}, n, -1, 0, rx, ok);
   endtask

   task automatic rd(input string req, input logic [7:0] ins, input logic [7:0] exp);
      logic [7:0] rx; bit ok;
      xfer({idb(), ins, 8'h00}, 24, -1, 0, rx, ok);
      chk(req, rx, exp);
      chk({req, " so_oe"}, ok, 1);
   endtask

   task automatic t_reset();
      cyc(20);
      chk("R1 wiper0", wip(0), 8'h80);
      chk("R1 wiper1", wip(1), 8'h90);
      chk("R1 wiper2", wip(2), 8'hA0);
      chk("R1 wiper3", wip(3), 8'hB0);
      chk("R1 so_oe", so_oe, 0);
      chk("R1 nv_req", nv_hi, 0);
   endtask

   task automatic t_no_start();
      logic [7:0] rx; bit ok;
      xfer({idb(), 4'b1010, 2'b00, 2'd0, 8'h11}, 24, -1, 1, rx, ok);
      chk("R12 no frame before cs high-low", wip(0), 8'h80);
      rd("R1 dr ch2 sel0", {4'b1011, 2'd0, 2'd2}, 8'hA0);
   endtask

   task automatic t_wiper();
      send(idb(), 4'b1010, 2'd0, 2'd2, 8'h3C, 24);
      chk("R3 wiper2 write", wip(2), 8'h3C);
      rd("R3 read wiper2", {4'b1001, 2'd0, 2'd2}, 8'h3C);
      send(idb(), 4'b1010, 2'd0, 2'd0, 8'hA5, 24);
      chk("R3 wiper0 write", wip(0), 8'hA5);
      rd("R3 read wiper0", {4'b1001, 2'd0, 2'd0}, 8'hA5);
   endtask

   task automatic t_ident();
      int oe0;
      logic [7:0] rx; bit ok;
      oe0 = oe_hi;
      send(8'h62, 4'b1010, 2'd0, 2'd1, 8'h00, 24);
      chk("R2 wrong type nibble", wip(1), 8'h90);
      send(8'h51, 4'b1010, 2'd0, 2'd1, 8'h00, 24);
      chk("R2 wrong address", wip(1), 8'h90);
      xfer({8'h51, 8'h91, 8'h00}, 24, -1, 0, rx, ok);
      chk("R2 no output on mismatch", oe_hi - oe0, 0);
   endtask

   task automatic t_store();
      int nv0;
      nv0 = nv_rise;
      send(idb(), 4'b1100, 2'd3, 2'd1, 8'h5A, 24);
      chk("R4 one request", nv_rise - nv0, 1);
      rd("R4 read dr ch1 sel3", {4'b1011, 2'd3, 2'd1}, 8'h5A);
   endtask

   task automatic t_protect();
      int nv0;
      nv0 = nv_rise;
      wp_n = 1'b0;
      send(idb(), 4'b1100, 2'd3, 2'd1, 8'h11, 24);
      send(idb(), 4'b1110, 2'd3, 2'd0, 8'h00, 16);
      chk("R5 no request", nv_rise - nv0, 0);
      rd("R5 dr ch1 sel3 kept", {4'b1011, 2'd3, 2'd1}, 8'h5A);
      rd("R5 dr ch0 sel3 kept", {4'b1011, 2'd3, 2'd0}, 8'h00);
      wp_n = 1'b1;
   endtask

   task automatic t_copy();
      int nv0;
      send(idb(), 4'b1101, 2'd3, 2'd1, 8'h00, 16);
      chk("R6 dr to wiper1", wip(1), 8'h5A);
      nv0 = nv_rise;
      send(idb(), 4'b1110, 2'd2, 2'd0, 8'h00, 16);
      chk("R6 wiper copy request", nv_rise - nv0, 1);
      rd("R6 wiper0 to dr sel2", {4'b1011, 2'd2, 2'd0}, 8'hA5);
   endtask

   task automatic t_global();
      int nv0;
      for (int c = 0; c < 4; c++) send(idb(), 4'b1100, 2'd1, 2'(c), 8'(8'h11 * (c + 1)), 24);
      send(idb(), 4'b0001, 2'd1, 2'd0, 8'h00, 16);
      for (int c = 0; c < 4; c++) chk("R7 global load", wip(c), 8'(8'h11 * (c + 1)));
      nv0 = nv_rise;
      send(idb(), 4'b1000, 2'd2, 2'd0, 8'h00, 16);
      chk("R7 global store request", nv_rise - nv0, 1);
      rd("R7 global store ch3", {4'b1011, 2'd2, 2'd3}, 8'h44);
      rd("R7 global store ch0", {4'b1011, 2'd2, 2'd0}, 8'h11);
   endtask

   task automatic t_status();
      nv_busy = 1'b1;
      rd("R8 status busy", 8'h51, 8'h01);
      nv_busy = 1'b0;
      rd("R8 status idle", 8'h51, 8'h00);
   endtask

   task automatic t_hold();
      logic [7:0] rx; bit ok;
      xfer({idb(), 4'b1010, 2'd0, 2'd3, 8'h9C}, 24, 10, 0, rx, ok);
      chk("R10 paused write", wip(3), 8'h9C);
      xfer({idb(), 4'b1001, 2'd0, 2'd3, 8'h00}, 24, 19, 0, rx, ok);
      chk("R10 paused read data", rx, 8'h9C);
      chk("R10 so_oe off in pause", ok, 1);
   endtask

   task automatic t_length();
      int nv0;
      nv0 = nv_rise;
      send(idb(), 4'b1010, 2'd0, 2'd3, 8'h00, 20);
      chk("R11 short frame", wip(3), 8'h9C);
      send(idb(), 4'b1010, 2'd0, 2'd3, 8'h00, 25);
      chk("R11 long frame", wip(3), 8'h9C);
      send(idb(), 4'b1111, 2'd0, 2'd3, 8'h00, 24);
      chk("R11 unsupported opcode", wip(3), 8'h9C);
      send(idb(), 4'b0010, 2'd0, 2'd3, 8'h00, 24);
      chk("R11 step opcode", wip(3), 8'h9C);
      send(idb(), 4'b1101, 2'd0, 2'd3, 8'h00, 24);
      chk("R11 copy with extra byte", wip(3), 8'h9C);
      send(idb(), 4'b1100, 2'd0, 2'd3, 8'h00, 20);
      chk("R11 cut store no request", nv_rise - nv0, 0);
      rd("R11 cut store kept", {4'b1011, 2'd0, 2'd3}, 8'hB0);
   endtask

   initial begin
      cyc(5);
      rst_n = 1'b1;
      t_reset();
      t_no_start();
      t_wiper();
      t_ident();
      t_store();
      t_protect();
      t_copy();
      t_global();
      t_status();
      t_hold();
      t_length();
      chk("R9 so_oe off while deselected", oe_idle_bad, 0);
      chk("R4 request one cycle each", nv_hi, nv_rise);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule